// File: doc/BRIEF.md
# Dual-Slot Stack Operation Sequencer

This block sits between instruction decode and a stack execution unit. It takes 16-bit instruction words, numbered with bit 0 as the most significant bit, so bit 0 is `instr_word[15]`. A word whose bits 0 to 3 are all zero is a stack-op word. Such a word holds two 6-bit operation slots: slot A in bits 4 to 9 (`instr_word[11:6]`) and slot B in bits 10 to 15 (`instr_word[5:0]`). The sequencer issues the two slots one at a time, A before B. Before it issues each operation it waits for the completion pulse of the one before. Code 000000 is the no-op and is never issued. Any other value in bits 0 to 3 is handed on unchanged as a non-stack word.

A pending interrupt can be accepted in the gap between slot A completing and slot B starting. The sequencer then stores slot B's code together with a resume flag and pulses `irq_taken`. It waits for `irq_resume` and then issues only slot B. The sequencer looks at slot B in advance. When slot B is a no-op, it raises `fetch_req` in the cycle right after slot A completes and spends no cycle on B. The carry, overflow and condition-code indicators are loaded from the execution unit on each completion, so they always describe the last operation that actually ran.

States and transitions:
- IDLE goes to PASS when a non-stack word is accepted.
- IDLE goes to ISSUE_A when a stack word with a non-zero slot A is accepted.
- IDLE goes to ISSUE_B when slot A is zero and slot B is not.
- IDLE goes to FINISH when both slots are zero.
- PASS goes to IDLE.
- ISSUE_A goes to WAIT_A.
- WAIT_A, on done, goes to FINISH if slot B is a no-op, to IRQ_TAKE if an interrupt is pending, and to ISSUE_B otherwise.
- IRQ_TAKE goes to IRQ_WAIT.
- IRQ_WAIT goes to ISSUE_B on resume.
- ISSUE_B goes to WAIT_B.
- WAIT_B goes to FINISH on done.
- FINISH goes to IDLE.

Top module: `stkop_seq`

## Requirements
- R1: A word accepted with `instr_word[15:12]` not zero produces no issue. In the following cycle it produces a one-cycle `pass_valid` with `pass_word` equal to the accepted word, and no `fetch_req`.
- R2: For a stack word with non-zero slot A, the first issue carries `op_code = instr_word[11:6]` and comes in the cycle after acceptance.
- R3: Slot B (`instr_word[5:0]`), when non-zero, is issued after slot A's done pulse. When slot A is zero, slot B is issued directly, in the cycle after acceptance.
- R4: `op_issue` is a one-cycle pulse. No further issue occurs until `exu_done` has been seen for the previous one.
- R5: When slot B is 000000, `fetch_req` pulses in the cycle right after slot A's done pulse, and slot B is never issued.
- R6: A stack word with both slots 000000 issues nothing and pulses `fetch_req` in the cycle after acceptance.
- R7: When `irq_pending` is high at slot A's done pulse and slot B is non-zero, `irq_taken` pulses once. Nothing is issued until `irq_resume`, after which slot B alone is issued.
- R8: No interrupt is taken when slot B is a no-op, when slot A is a no-op, or for a non-stack word.
- R9: `carry`, `ovfl` and `cc` load `exu_carry`, `exu_ovfl` and `exu_cc` on each done pulse of an issued operation, and hold otherwise.
- R10: `instr_ready` is high only in IDLE. Words presented while the block is busy are ignored.
- R11: After reset, `instr_ready` is 1, `op_issue`, `fetch_req`, `irq_taken` and `pass_valid` are 0, and all indicators are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 16 | Instruction word, bit 0 = MSB |
| instr_ready | output | 1 | Sequencer idle, word accepted |
| irq_pending | input | 1 | Interrupt request waiting |
| irq_resume | input | 1 | Return from interrupt, continue with slot B |
| exu_done | input | 1 | Execution unit finished the issued operation |
| exu_carry | input | 1 | Carry result of finished operation |
| exu_ovfl | input | 1 | Overflow result of finished operation |
| exu_cc | input | 2 | Condition-code result of finished operation |
| op_issue | output | 1 | Operation issue strobe |
| op_code | output | 6 | Stack operation code being issued |
| irq_taken | output | 1 | Interrupt accepted between slots |
| fetch_req | output | 1 | Request for the next instruction word |
| pass_valid | output | 1 | Non-stack word handed on |
| pass_word | output | 16 | The non-stack word |
| carry | output | 1 | Carry indicator |
| ovfl | output | 1 | Overflow indicator |
| cc | output | 2 | Condition-code indicator |

## Verification
The hardest state to reach is the interrupt window. `irq_pending` must be high in the exact cycle that slot A's done pulse arrives, and slot B must be non-zero. A resumed slot B must then be told apart from a second issue of slot A. The bench holds `irq_pending` for a whole word and varies the execution latency at random. It answers `irq_taken` with a delayed `irq_resume`. It compares the complete list of issued codes with the list expected from the two slots, so any re-issue of slot A or any missing slot B shows up. It also keeps a different decoy word offered during every busy period, which shows that words are ignored while the sequencer works.

// File: rtl/stkop_pkg.sv
package stkop_pkg;
    localparam int WORD_W = 16;
    localparam int GRP_W  = 4;
    localparam int OP_W   = 6;
    localparam int CC_W   = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PASS,
        S_ISSUE_A,
        S_WAIT_A,
        S_IRQ_TAKE,
        S_IRQ_WAIT,
        S_ISSUE_B,
        S_WAIT_B,
        S_FINISH
    } seq_state_t;
endpackage

// File: rtl/stkop_decode.sv
module stkop_decode #(
    parameter int WORD_W = stkop_pkg::WORD_W,
    parameter int GRP_W  = stkop_pkg::GRP_W,
    parameter int OP_W   = stkop_pkg::OP_W
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_stack,
    output logic [OP_W-1:0]   slot_a,
    output logic [OP_W-1:0]   slot_b,
    output logic              a_nop,
    output logic              b_nop
);
    localparam int NSLOTS  = (WORD_W - GRP_W) / OP_W;
    localparam int SLOTTOP = WORD_W - GRP_W - 1;

    logic [OP_W-1:0] slots [NSLOTS];

    // slots are laid out left to right below the group field
    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        assign slots[g] = word[SLOTTOP - g*OP_W -: OP_W];
    end

    assign is_stack = (word[WORD_W-1 -: GRP_W] == '0);
    assign slot_a   = slots[0];
    assign slot_b   = slots[1];
    assign a_nop    = (slots[0] == '0);
    assign b_nop    = (slots[1] == '0);
endmodule

// File: rtl/stkop_fsm.sv
module stkop_fsm
    import stkop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  logic in_stack,
    input  logic in_a_nop,
    input  logic in_b_nop,
    input  logic held_b_nop,
    input  logic irq_pending,
    input  logic irq_resume,
    input  logic exu_done,
    output logic instr_ready,
    output logic load_word,
    output logic issue_a,
    output logic issue_b,
    output logic irq_taken,
    output logic save_resume,
    output logic fetch_req,
    output logic pass_valid,
    output logic flag_we
);
    seq_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (instr_valid) begin
                    if (!in_stack)      state_nx = S_PASS;
                    else if (!in_a_nop) state_nx = S_ISSUE_A;
                    else if (!in_b_nop) state_nx = S_ISSUE_B;
                    else                state_nx = S_FINISH;
                end
            end
            S_PASS:     state_nx = S_IDLE;
            S_ISSUE_A:  state_nx = S_WAIT_A;
            S_WAIT_A: begin
                if (exu_done) begin
                    if (held_b_nop)       state_nx = S_FINISH;
                    else if (irq_pending) state_nx = S_IRQ_TAKE;
                    else                  state_nx = S_ISSUE_B;
                end
            end
            S_IRQ_TAKE: state_nx = S_IRQ_WAIT;
            S_IRQ_WAIT: if (irq_resume) state_nx = S_ISSUE_B;
            S_ISSUE_B:  state_nx = S_WAIT_B;
            S_WAIT_B:   if (exu_done) state_nx = S_FINISH;
            S_FINISH:   state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        instr_ready = (state == S_IDLE);
        load_word   = (state == S_IDLE) && instr_valid;
        issue_a     = (state == S_ISSUE_A);
        issue_b     = (state == S_ISSUE_B);
        irq_taken   = (state == S_IRQ_TAKE);
        save_resume = (state == S_IRQ_TAKE);
        fetch_req   = (state == S_FINISH);
        pass_valid  = (state == S_PASS);
        flag_we     = exu_done && ((state == S_WAIT_A) || (state == S_WAIT_B));
    end
endmodule

// File: rtl/stkop_flags.sv
module stkop_flags #(
    parameter int CC_W = stkop_pkg::CC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            c_in,
    input  logic            v_in,
    input  logic [CC_W-1:0] cc_in,
    output logic            c_q,
    output logic            v_q,
    output logic [CC_W-1:0] cc_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q  <= 1'b0;
            v_q  <= 1'b0;
            cc_q <= '0;
        end else if (we) begin
            c_q  <= c_in;
            v_q  <= v_in;
            cc_q <= cc_in;
        end
    end
endmodule

// File: rtl/stkop_resume.sv
module stkop_resume #(
    parameter int OP_W = stkop_pkg::OP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save,
    input  logic            consume,
    input  logic [OP_W-1:0] live_b,
    output logic [OP_W-1:0] code_b
);
    logic            pend_q;
    logic [OP_W-1:0] saved_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            saved_q <= '0;
        end else if (save) begin
            pend_q  <= 1'b1;
            saved_q <= live_b;
        end else if (consume) begin
            pend_q  <= 1'b0;
        end
    end

    assign code_b = pend_q ? saved_q : live_b;
endmodule

// File: rtl/stkop_seq.sv
module stkop_seq #(
    parameter int WORD_W = stkop_pkg::WORD_W,
    parameter int GRP_W  = stkop_pkg::GRP_W,
    parameter int OP_W   = stkop_pkg::OP_W,
    parameter int CC_W   = stkop_pkg::CC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    output logic              instr_ready,
    input  logic              irq_pending,
    input  logic              irq_resume,
    input  logic              exu_done,
    input  logic              exu_carry,
    input  logic              exu_ovfl,
    input  logic [CC_W-1:0]   exu_cc,
    output logic              op_issue,
    output logic [OP_W-1:0]   op_code,
    output logic              irq_taken,
    output logic              fetch_req,
    output logic              pass_valid,
    output logic [WORD_W-1:0] pass_word,
    output logic              carry,
    output logic              ovfl,
    output logic [CC_W-1:0]   cc
);
    logic            in_stack, in_a_nop, in_b_nop;
    logic [OP_W-1:0] in_a, in_b;
    logic [OP_W-1:0] held_a, held_b, code_b;
    logic            held_b_nop;
    logic            load_word, issue_a, issue_b, save_resume, flag_we;
    logic [WORD_W-1:0] word_q;

    stkop_decode #(.WORD_W(WORD_W), .GRP_W(GRP_W), .OP_W(OP_W)) u_dec (
        .word(instr_word), .is_stack(in_stack), .slot_a(in_a), .slot_b(in_b),
        .a_nop(in_a_nop), .b_nop(in_b_nop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_a     <= '0;
            held_b     <= '0;
            held_b_nop <= 1'b1;
            word_q     <= '0;
        end else if (load_word) begin
            held_a     <= in_a;
            held_b     <= in_b;
            held_b_nop <= in_b_nop;
            word_q     <= instr_word;
        end
    end

    stkop_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .in_stack(in_stack), .in_a_nop(in_a_nop), .in_b_nop(in_b_nop),
        .held_b_nop(held_b_nop), .irq_pending(irq_pending),
        .irq_resume(irq_resume), .exu_done(exu_done),
        .instr_ready(instr_ready), .load_word(load_word),
        .issue_a(issue_a), .issue_b(issue_b), .irq_taken(irq_taken),
        .save_resume(save_resume), .fetch_req(fetch_req),
        .pass_valid(pass_valid), .flag_we(flag_we)
    );

    stkop_resume #(.OP_W(OP_W)) u_res (
        .clk(clk), .rst_n(rst_n), .save(save_resume), .consume(issue_b),
        .live_b(held_b), .code_b(code_b)
    );

    stkop_flags #(.CC_W(CC_W)) u_flg (
        .clk(clk), .rst_n(rst_n), .we(flag_we),
        .c_in(exu_carry), .v_in(exu_ovfl), .cc_in(exu_cc),
        .c_q(carry), .v_q(ovfl), .cc_q(cc)
    );

    assign op_issue  = issue_a | issue_b;
    assign op_code   = issue_a ? held_a : (issue_b ? code_b : '0);
    assign pass_word = word_q;
endmodule

module stkop_seq_chk #(
    parameter int WORD_W = 16,
    parameter int GRP_W  = 4,
    parameter int OP_W   = 6,
    parameter int CC_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_ready,
    input logic              exu_done,
    input logic              op_issue,
    input logic [OP_W-1:0]   op_code,
    input logic              irq_taken,
    input logic              fetch_req,
    input logic              pass_valid,
    input logic [WORD_W-1:0] pass_word,
    input logic              carry,
    input logic              ovfl,
    input logic [CC_W-1:0]   cc
);
    assert_pass_nonstack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> (pass_word[WORD_W-1 -: GRP_W] != '0) && !op_issue);

    assert_no_nop_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_issue |-> (op_code != '0));

    assert_issue_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_issue |=> !op_issue);

    assert_outputs_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_issue, fetch_req, pass_valid, irq_taken}));

    assert_irq_then_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !op_issue && !instr_ready);

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !exu_done |=> $stable({carry, ovfl, cc}));

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ready |-> !op_issue && !fetch_req && !irq_taken && !pass_valid);
endmodule

bind stkop_seq stkop_seq_chk #(.WORD_W(WORD_W), .GRP_W(GRP_W), .OP_W(OP_W), .CC_W(CC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .instr_ready(instr_ready), .exu_done(exu_done),
    .op_issue(op_issue), .op_code(op_code), .irq_taken(irq_taken),
    .fetch_req(fetch_req), .pass_valid(pass_valid), .pass_word(pass_word),
    .carry(carry), .ovfl(ovfl), .cc(cc)
);

// File: tb/stkop_seq_test.sv
`timescale 1ns/1ps
module stkop_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        instr_ready;
    logic        irq_pending = 1'b0;
    logic        irq_resume = 1'b0;
    logic        exu_done = 1'b0;
    logic        exu_carry = 1'b0;
    logic        exu_ovfl = 1'b0;
    logic [1:0]  exu_cc = '0;
    logic        op_issue;
    logic [5:0]  op_code;
    logic        irq_taken, fetch_req, pass_valid;
    logic [15:0] pass_word;
    logic        carry, ovfl;
    logic [1:0]  cc;

    int total = 0;
    int fails = 0;
    logic [3:0] exp_flags = '0;

    always #2 clk = ~clk;

    stkop_seq uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_ready(instr_ready), .irq_pending(irq_pending), .irq_resume(irq_resume),
        .exu_done(exu_done), .exu_carry(exu_carry), .exu_ovfl(exu_ovfl), .exu_cc(exu_cc),
        .op_issue(op_issue), .op_code(op_code), .irq_taken(irq_taken),
        .fetch_req(fetch_req), .pass_valid(pass_valid), .pass_word(pass_word),
        .carry(carry), .ovfl(ovfl), .cc(cc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int a, input int b);
        return 16'((a & 63) << 6) | 16'(b & 63);
    endfunction

    function automatic bit is_stk(input logic [15:0] w);
        return w[15:12] == 4'h0;
    endfunction

    function automatic int exp_issues(input logic [15:0] w);
        if (!is_stk(w)) return 0;
        return int'(w[11:6] != 0) + int'(w[5:0] != 0);
    endfunction

    function automatic int exp_irq(input logic [15:0] w, input bit irq);
        return int'(irq && is_stk(w) && w[11:6] != 0 && w[5:0] != 0);
    endfunction

    task automatic run_word(input logic [15:0] w, input bit irq, input int lat);
        logic [5:0] got [4];
        int ngot = 0, nirq = 0, cnt = 0, rcnt = 0, nexp;
        bit fin = 0, saw_pass = 0, saw_fetch = 0, busy_ready = 0;
        logic [15:0] pw = '0;
        @(negedge clk);
        chk(instr_ready === 1'b1, "R10 ready before word", int'(instr_ready), 1);
        instr_valid = 1'b1;
        instr_word  = w;
        irq_pending = irq;
        for (int cyc = 0; cyc < 60 && !fin; cyc++) begin
            @(negedge clk);
            exu_done   = 1'b0;
            irq_resume = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    exu_done  = 1'b1;
                    exu_carry = 1'($urandom);
                    exu_ovfl  = 1'($urandom);
                    exu_cc    = 2'($urandom);
                    exp_flags = {exu_carry, exu_ovfl, exu_cc};
                end
            end
            if (rcnt > 0) begin
                rcnt--;
                if (rcnt == 0) irq_resume = 1'b1;
            end
            if (op_issue) begin
                if (ngot < 4) got[ngot] = op_code;
                ngot++;
                cnt = lat;
            end
            if (irq_taken) begin
                nirq++;
                rcnt = 3;
            end
            if (pass_valid) begin saw_pass = 1; pw = pass_word; end
            if (fetch_req) saw_fetch = 1;
            if (pass_valid || fetch_req) begin
                fin = 1;
                instr_valid = 1'b0;
            end else begin
                if (instr_ready) busy_ready = 1;
                instr_valid = 1'b1;
                instr_word  = mk(21, 42);
            end
        end
        irq_pending = 1'b0;
        exu_done = 1'b0;
        nexp = exp_issues(w);
        chk(!busy_ready, "R10 ready low while busy", int'(busy_ready), 0);
        if (!is_stk(w)) begin
            chk(saw_pass && pw == w, "R1 pass word", int'(pw), int'(w));
            chk(!saw_fetch, "R1 no fetch", int'(saw_fetch), 0);
        end else begin
            chk(saw_fetch && !saw_pass, "R5 R6 fetch at end", int'(saw_fetch), 1);
        end
        chk(ngot == nexp, "R4 R6 issue count", ngot, nexp);
        if (ngot == nexp && nexp > 0) begin
            if (w[11:6] != 0) begin
                chk(got[0] == w[11:6], "R2 slot A code", int'(got[0]), int'(w[11:6]));
                if (nexp == 2)
                    chk(got[1] == w[5:0], "R3 slot B code after A", int'(got[1]), int'(w[5:0]));
            end else begin
                chk(got[0] == w[5:0], "R3 slot B direct", int'(got[0]), int'(w[5:0]));
            end
        end
        chk(nirq == exp_irq(w, irq), "R7 R8 irq taken count", nirq, exp_irq(w, irq));
        chk({carry, ovfl, cc} == exp_flags, "R9 indicators", int'({carry, ovfl, cc}), int'(exp_flags));
    endtask

    // R5 timing: fetch_req exactly one cycle after A's done when B is a no-op
    task automatic b_skip_timing();
        int gap = -1;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = mk(9, 0);
        @(negedge clk);
        instr_valid = 1'b0;
        chk(op_issue === 1'b1, "R2 issue in cycle after accept", int'(op_issue), 1);
        @(negedge clk);
        exu_done = 1'b1;
        exu_carry = 1'b1; exu_ovfl = 1'b0; exu_cc = 2'b10;
        exp_flags = 4'b1010;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            exu_done = 1'b0;
            if (fetch_req && gap < 0) gap = k;
            chk(!op_issue, "R5 slot B not issued", int'(op_issue), 0);
        end
        chk(gap == 0, "R5 fetch right after A done", gap, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd1931));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(instr_ready === 1'b1, "R11 ready", int'(instr_ready), 1);
        chk(op_issue === 1'b0 && fetch_req === 1'b0 && irq_taken === 1'b0 && pass_valid === 1'b0,
            "R11 strobes low", int'({op_issue, fetch_req, irq_taken, pass_valid}), 0);
        chk({carry, ovfl, cc} === 4'b0, "R11 indicators", int'({carry, ovfl, cc}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_word(mk(0, 0), 1'b1, 1);     // R6 both no-op, R8
        run_word(mk(0, 5), 1'b1, 2);     // R3 direct B, R8
        run_word(mk(7, 0), 1'b1, 3);     // R5, R8
        run_word(mk(63, 63), 1'b1, 1);   // R7
        run_word(mk(3, 9), 1'b1, 4);     // R7 long latency
        run_word(mk(12, 34), 1'b0, 2);   // R2 R3
        run_word(16'h1234, 1'b1, 1);     // R1 R8
        run_word(16'hF000, 1'b0, 1);     // R1
        b_skip_timing();

        for (int i = 0; i < 300; i++) begin
            logic [15:0] w;
            int a, b;
            a = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 63));
            b = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 63));
            w = mk(a, b);
            if ($urandom_range(0, 4) == 0) w[15:12] = 4'($urandom_range(1, 15));
            run_word(w, 1'($urandom), int'($urandom_range(1, 4)));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule